// File: doc/BRIEF.md
# Write-Completion Acknowledge Polling Master

A host-side two-wire bus controller. It finds out when a serial EEPROM has finished its internal write cycle by asking it, so the host does not have to wait a fixed worst-case delay. The caller issues the STOP that starts the device's write cycle on its own, then pulses `start_poll`. The block then repeats one attempt until the device answers. An attempt is a bus-free gap, a START, and the control byte (device code `1010000` followed by a write direction bit of 0). The block releases SDA for the ninth clock and samples it. A device that is still writing leaves the ninth clock unacknowledged. The block then sends STOP and starts another attempt.

Once the device acknowledges, the block keeps SCL pulled low with SDA released, so the bus stays owned. It also pulses `ready`. The caller can then either continue or pulse `release_bus` to get a STOP. If a configurable number of attempts all fail, the block sends a final STOP, returns to idle and raises `timeout`. SCL and SDA are driven as open-drain pull-down enables. The low and high phase lengths are counted in system clocks. The defaults give at least 4.7 us low and 4.0 us high with a 125 MHz clock.

Top module: `ackpoll_master`

## Requirements
- R1: After reset `scl_oe`, `sda_oe`, `busy`, `ready`, `timeout` and `bus_held` are all 0.
- R2: A `start_poll` pulse in idle raises `busy` from the next cycle. The block then leaves both lines released for LOW_CYC cycles. It then holds a START for HIGH_CYC cycles: `sda_oe`=1 with `scl_oe`=0.
- R3: The control byte `{DEV_CODE,0}` (default 8'hA0) is sent MSB first. Each bit has a low phase of LOW_CYC cycles with `scl_oe`=1, followed by a high phase of HIGH_CYC cycles with `scl_oe`=0. A 0 bit is `sda_oe`=1. `sda_oe` takes the new bit's value only from the second cycle of the low phase, so SDA and SCL never change in the same cycle.
- R4: For the ninth clock `sda_oe` is 0. The acknowledge is sampled on the last cycle of the ninth high phase. A low `sda_in` is an ACK.
- R5: On a NACK the block sends STOP and retries. STOP is a low phase of LOW_CYC cycles with `sda_oe`=1 from its second cycle, then HIGH_CYC cycles of `scl_oe`=0, `sda_oe`=1. The next attempt then begins with the R2 gap.
- R6: On an ACK the block enters a hold state with `scl_oe`=1, `sda_oe`=0 and `bus_held`=1. `ready` is 1 only in the first hold cycle, and `busy` is 0 from that cycle on.
- R7: If MAX_TRIES attempts in a row are not acknowledged, the block sends the STOP of R5 and goes idle. `busy` falls and `timeout` rises in the same cycle, and `timeout` stays 1 until the next accepted `start_poll`.
- R8: `release_bus` in the hold state drops `bus_held` at once. The block then sends the STOP sequence of R5 with `busy`=0 and returns to idle with both lines released.
- R9: `start_poll` has no effect unless the block is idle. `release_bus` has no effect unless the block is in the hold state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_poll | input | 1 | One-cycle request to begin polling |
| release_bus | input | 1 | One-cycle request to STOP after a successful poll |
| sda_in | input | 1 | Sampled level of the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| busy | output | 1 | Polling in progress |
| ready | output | 1 | One-cycle pulse when the device has acknowledged |
| timeout | output | 1 | All attempts were refused; held until the next poll |
| bus_held | output | 1 | SCL is held low after a successful acknowledge |

## Verification
The bench builds the block with LOW_CYC=5, HIGH_CYC=4 and MAX_TRIES=3, so one attempt lasts about a hundred cycles. With these values the bench can run an immediate ACK, an ACK after two refusals, and a full timeout after three refusals in a short run. A small behavioural slave on the wired bus refuses a chosen number of attempts and checks the received control byte. The phase lengths differ, so the bench detects a low phase and a high phase swapped or counted one cycle too long.

// File: rtl/ackpoll_master.sv
module ackpoll_master #(
  parameter int LOW_CYC = 600,
  parameter int HIGH_CYC = 520,
  parameter int MAX_TRIES = 255,
  parameter logic [6:0] DEV_CODE = 7'b1010000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_poll,
  input  logic release_bus,
  input  logic sda_in,
  output logic scl_oe,
  output logic sda_oe,
  output logic busy,
  output logic ready,
  output logic timeout,
  output logic bus_held
);

  localparam int PH_MAX = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
  localparam int CW = $clog2(PH_MAX + 1);
  localparam int TW = $clog2(MAX_TRIES + 1);
  localparam logic [CW-1:0] LO_LAST = CW'(LOW_CYC - 1);
  localparam logic [CW-1:0] HI_LAST = CW'(HIGH_CYC - 1);
  localparam logic [TW-1:0] TRY_LAST = TW'(MAX_TRIES - 1);
  localparam logic [7:0] CTRL = {DEV_CODE, 1'b0};

  typedef enum logic [2:0] {
    S_IDLE, S_GAP, S_START, S_LO, S_HI, S_TAIL, S_STOP, S_HOLD
  } st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic [3:0] bitn;
  logic [TW-1:0] tries;
  logic again, quit;

  function automatic logic drv(input logic [3:0] k);
    if (k >= 4'd8) return 1'b0;
    return !CTRL[3'(4'd7 - k)];
  endfunction

  wire long_ph = (st == S_GAP) || (st == S_LO) || (st == S_TAIL);
  wire ph_end = long_ph ? (cnt == LO_LAST) : (cnt == HI_LAST);
  wire first = (cnt == '0);
  wire prev_bit = (bitn == 4'd0) ? 1'b1 : drv(bitn - 4'd1);

  assign scl_oe = (st == S_LO) || (st == S_TAIL) || (st == S_HOLD);
  assign bus_held = (st == S_HOLD);
  assign busy = (st == S_GAP) || (st == S_START) || (st == S_LO) || (st == S_HI) ||
                (((st == S_TAIL) || (st == S_STOP)) && (again || quit));

  always_comb begin
    case (st)
      S_START: sda_oe = 1'b1;
      S_LO:    sda_oe = first ? prev_bit : drv(bitn);
      S_HI:    sda_oe = drv(bitn);
      S_TAIL:  sda_oe = !first;
      S_STOP:  sda_oe = 1'b1;
      default: sda_oe = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      bitn <= 4'd0;
      tries <= '0;
      again <= 1'b0;
      quit <= 1'b0;
      ready <= 1'b0;
      timeout <= 1'b0;
    end else begin
      ready <= 1'b0;
      cnt <= ph_end ? '0 : cnt + 1'b1;
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (start_poll) begin
            st <= S_GAP;
            tries <= '0;
            timeout <= 1'b0;
            again <= 1'b0;
            quit <= 1'b0;
          end
        end
        S_GAP:   if (ph_end) st <= S_START;
        S_START: if (ph_end) begin st <= S_LO; bitn <= 4'd0; end
        S_LO:    if (ph_end) st <= S_HI;
        S_HI: begin
          if (ph_end) begin
            if (bitn != 4'd8) begin
              bitn <= bitn + 4'd1;
              st <= S_LO;
            end else if (!sda_in) begin
              st <= S_HOLD;
              ready <= 1'b1;
            end else begin
              st <= S_TAIL;
              again <= (tries != TRY_LAST);
              quit <= (tries == TRY_LAST);
              tries <= tries + 1'b1;
            end
          end
        end
        S_TAIL: if (ph_end) st <= S_STOP;
        S_STOP: begin
          if (ph_end) begin
            st <= again ? S_GAP : S_IDLE;
            if (quit) timeout <= 1'b1;
          end
        end
        S_HOLD: begin
          cnt <= '0;
          if (release_bus) begin
            st <= S_TAIL;
            again <= 1'b0;
            quit <= 1'b0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R3
  sda_scl_skew_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scl_oe) |-> $stable(sda_oe));
  // R3
  data_high_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HI && $past(st) == S_HI) |-> $stable(sda_oe));
  // R6
  ready_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (bus_held && scl_oe && !sda_oe && !busy));
  // R7
  timeout_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> $fell(busy));
  // R9
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_held && !release_bus) |=> bus_held);
  // R4
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HI && bitn == 4'd8) |-> !sda_oe);

endmodule

// File: tb/ackpoll_master_test.sv
module ackpoll_master_test;
  localparam int L = 5;
  localparam int H = 4;
  localparam int M = 3;
  localparam logic [7:0] CTRL = 8'hA0;

  logic clk = 1'b0, rst_n = 1'b0, start_poll = 1'b0, release_bus = 1'b0;
  logic sda_in, scl_oe, sda_oe, busy, ready, timeout, bus_held;
  logic slv_low = 1'b0;
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit checking = 1'b0;

  assign sda_in = !(sda_oe || slv_low);

  ackpoll_master #(.LOW_CYC(L), .HIGH_CYC(H), .MAX_TRIES(M)) uut (
    .clk(clk), .rst_n(rst_n), .start_poll(start_poll), .release_bus(release_bus),
    .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .ready(ready),
    .timeout(timeout), .bus_held(bus_held));

  always #4 clk = !clk;

  // expected {scl_oe, sda_oe, busy, ready, timeout, bus_held}
  logic [5:0] exp_q[$];
  int tag_q[$];
  logic [5:0] idle_exp = 6'b0;
  int idle_tag = 1;

  task automatic push(input logic [5:0] v, input int tag, input int n);
    for (int i = 0; i < n; i++) begin exp_q.push_back(v); tag_q.push_back(tag); end
  endtask

  function automatic logic bit_oe(input int k);
    if (k >= 8) return 1'b0;
    return !CTRL[7 - k];
  endfunction

  task automatic gen_attempt(input bit ack, input bit last);
    push(6'b001000, 2, L);            // R2 gap
    push(6'b011000, 2, H);            // R2 start
    for (int k = 0; k < 9; k++) begin
      logic p, c;
      int t;
      p = (k == 0) ? 1'b1 : bit_oe(k - 1);
      c = bit_oe(k);
      t = (k == 8) ? 4 : 3;           // R3 data bits, R4 ack clock
      push({1'b1, p, 4'b1000}, t, 1);
      push({1'b1, c, 4'b1000}, t, L - 1);
      push({1'b0, c, 4'b1000}, t, H);
    end
    if (ack) begin
      push(6'b100101, 6, 1);          // R6 ready pulse
      idle_exp = 6'b100001; idle_tag = 6;
    end else begin
      push(6'b101000, 5, 1);          // R5 stop
      push(6'b111000, 5, L - 1);
      push(6'b011000, 5, H);
      if (last) begin idle_exp = 6'b000010; idle_tag = 7; end   // R7
    end
  endtask

  int slave_busy = 0;

  task automatic poll(input int nbusy);
    @(posedge clk); #1;
    slave_busy = nbusy;
    start_poll = 1'b1;
    push(idle_exp, idle_tag, 1);
    for (int a = 0; a < M; a++) begin
      gen_attempt(a == nbusy, a == M - 1);
      if (a == nbusy) break;
    end
    @(posedge clk); #1 start_poll = 1'b0;
  endtask

  task automatic release_it();
    @(posedge clk); #1;
    release_bus = 1'b1;
    push(idle_exp, idle_tag, 1);
    push(6'b100000, 8, 1);            // R8 stop after hold
    push(6'b110000, 8, L - 1);
    push(6'b010000, 8, H);
    idle_exp = 6'b000000; idle_tag = 8;
    @(posedge clk); #1 release_bus = 1'b0;
  endtask

  // pulse an input that must be ignored (R9); no change expected
  task automatic stray(input bit which);
    @(posedge clk); #1;
    if (which) release_bus = 1'b1; else start_poll = 1'b1;
    @(posedge clk); #1;
    release_bus = 1'b0; start_poll = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  // reference comparison and bus slave
  logic p_scl = 1'b1, p_sda = 1'b1;
  bit s_act = 1'b0, s_ack = 1'b0;
  int s_bits = 0;
  logic [7:0] s_byte = 8'h00;

  always @(negedge clk) begin
    logic [5:0] e, a;
    int t;
    logic scl, sda;
    if (checking) begin
      if (exp_q.size() != 0) begin e = exp_q.pop_front(); t = tag_q.pop_front(); end
      else begin e = idle_exp; t = idle_tag; end
      a = {scl_oe, sda_oe, busy, ready, timeout, bus_held};
      n_chk++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL R%0d cycle %0d: got %b expected %b (scl_oe sda_oe busy ready timeout bus_held)",
                 t, cyc, a, e);
      end
    end
    scl = !scl_oe;
    sda = sda_in;
    if (p_scl && scl && p_sda && !sda) begin s_act = 1'b1; s_bits = 0; s_ack = 1'b0; end
    else if (p_scl && scl && !p_sda && sda) begin s_act = 1'b0; slv_low = 1'b0; end
    else if (!p_scl && scl && s_act && s_bits < 8) begin s_byte = {s_byte[6:0], sda}; s_bits++; end
    else if (p_scl && !scl && s_act) begin
      if (s_ack) begin slv_low = 1'b0; s_ack = 1'b0; s_act = 1'b0; end
      else if (s_bits == 8) begin
        s_ack = 1'b1;
        if (s_byte == CTRL && slave_busy == 0) slv_low = 1'b1;
        else if (s_byte == CTRL) slave_busy--;
      end
    end
    p_scl = scl;
    p_sda = sda;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: run hung at cycle %0d, expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;                          // R1 outputs inside reset
    if ({scl_oe, sda_oe, busy, ready, timeout, bus_held} !== 6'b0) begin
      n_fail++;
      $display("FAIL R1 in reset: got %b expected 000000",
               {scl_oe, sda_oe, busy, ready, timeout, bus_held});
    end
    @(posedge clk); #1 rst_n = 1'b1;
    checking = 1'b1;
    repeat (4) @(negedge clk);        // R1 idle after reset

    poll(0); drain();                 // R6 immediate ACK
    stray(1'b0); repeat (5) @(negedge clk);   // R9 start in hold ignored
    release_it(); drain();            // R8

    stray(1'b1); repeat (5) @(negedge clk);   // R9 release in idle ignored

    poll(2);                          // R5 two refusals then ACK
    repeat (30) @(negedge clk);
    stray(1'b1);                      // R9 release while polling
    repeat (40) @(negedge clk);
    stray(1'b0);                      // R9 start while polling
    drain();
    release_it(); drain();

    poll(7); drain();                 // R7 timeout after M attempts
    stray(1'b1); repeat (5) @(negedge clk);

    poll(1); drain();                 // R7 timeout cleared, R5 retry then ACK
    release_it(); drain();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule